// File: doc/BRIEF.md
# Register Command Stream Decoder

This block sits behind a byte transport and turns a stream of small commands into the contents of a bank of 8-bit video control registers. Bytes arrive under a valid/ready handshake. The decoder looks for a fixed prefix byte and then an opcode. For a register write, one address byte and one data byte follow. The committed bank drives a display timing generator through a flat bus. A few well-known registers are also decoded into dedicated outputs: colour depth, the two framebuffer base addresses, and the sync/power state.

Software can bracket a group of writes with a lock and an unlock, both issued through a reserved address. While the bank is locked, writes reach only a shadow copy. The unlock moves every shadow value into the live bank on one clock edge, so the timing generator never sees a half-updated mode. The control register selects one of three states: sync running, outputs blanked but powered, or powered down. The powered-down state persists until a complete register set is committed with sync running.

Top module: `regcmd_decoder`

## Requirements
- R1: After reset every register reads 0x00, the bank is unlocked, `in_ready` is 1, and both `sync_en` and `power_en` are 0.
- R2: The sequence 0xAF, 0x20, A, D with A < NUM_REGS, issued while unlocked, sets register A to D. The new value is visible on `bank_flat` (register A at bits 8*A+7 down to 8*A) in the cycle after the data byte is accepted.
- R3: Any byte other than 0xAF that arrives where a prefix is expected is dropped, and the decoder keeps waiting for 0xAF.
- R4: If the opcode byte after a prefix is not 0x20, the command is abandoned and the decoder goes back to searching for a prefix. Following bytes that are not 0xAF change nothing.
- R5: A write to an address at or above NUM_REGS, other than 0xFF, changes no register.
- R6: Writing 0x00 to address 0xFF locks the bank and raises `locked`. While locked, writes update only the shadow copy and `bank_flat` does not change.
- R7: Writing 0xFF to address 0xFF drops `in_ready` for exactly the next cycle. At the end of that cycle every shadow value is copied into the live bank and `locked` falls. Any other data written to 0xFF has no effect.
- R8: Register 0x1F selects the output state. 0x00 gives `sync_en`=1 and `power_en`=1. 0x07 gives both 0. Every other value, including 0x01, gives `sync_en`=0 and `power_en`=1.
- R9: After reset, or after 0x1F becomes 0x07, both outputs stay 0 until an unlock commits a set in which register 0x1F is 0x00. A direct unlocked write of 0x00 to 0x1F does not restore them.
- R10: `depth_deep` is bit 0 of register 0x00. `base_wide` is {reg 0x20, reg 0x21, reg 0x22}. `base_narrow` is {reg 0x26, reg 0x27, reg 0x28}. In both bases the lowest address is the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder can accept a byte |
| bank_flat | output | NUM_REGS*8 | Live register bank, register i at bits 8*i+7:8*i |
| locked | output | 1 | Bank is locked, writes go to shadow only |
| depth_deep | output | 1 | Deeper colour mode selected |
| base_wide | output | 24 | 16 bpp framebuffer base |
| base_narrow | output | 24 | 8 bpp framebuffer base |
| sync_en | output | 1 | Horizontal and vertical sync enabled |
| power_en | output | 1 | Display path powered |

## Verification
A direct write becomes visible on the bank and on the decoded outputs one edge after its data byte is accepted. The bench therefore samples at the falling edge that follows that acceptance. An unlock takes one more edge. The bench checks that `in_ready` is low at the first falling edge after the unlock byte, then waits one more falling edge before it compares the committed bank. All inputs change and all outputs are read on falling edges, so each comparison sits exactly where the register count puts the result.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam logic [7:0] CMD_PREFIX  = 8'hAF;
  localparam logic [7:0] OP_REGWR    = 8'h20;
  localparam logic [7:0] GUARD_ADDR  = 8'hFF;
  localparam logic [7:0] GUARD_LOCK  = 8'h00;
  localparam logic [7:0] GUARD_OPEN  = 8'hFF;
  localparam logic [7:0] CTL_RUN     = 8'h00;
  localparam logic [7:0] CTL_OFF     = 8'h07;
  localparam int         CTL_IDX     = 31;
  localparam int         DEPTH_IDX   = 0;
  localparam int         BASE_W_IDX  = 32;
  localparam int         BASE_N_IDX  = 38;

  typedef enum logic [1:0] {P_HUNT, P_OPC, P_ADDR, P_DATA} pstate_e;

  function automatic logic is_lock(input logic [7:0] a, input logic [7:0] d);
    return (a == GUARD_ADDR) && (d == GUARD_LOCK);
  endfunction

  function automatic logic is_open(input logic [7:0] a, input logic [7:0] d);
    return (a == GUARD_ADDR) && (d == GUARD_OPEN);
  endfunction

  // returns {power, sync} for a control value and the power-down hold flag
  function automatic logic [1:0] out_state(input logic [7:0] ctl, input logic hold);
    logic pw;
    pw = !hold && (ctl != CTL_OFF);
    return {pw, pw && (ctl == CTL_RUN)};
  endfunction
endpackage

// File: rtl/regcmd_parser.sv
module regcmd_parser
  import regcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       ready,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  pstate_e    st_q;
  logic [7:0] addr_q;
  logic       accept;

  assign accept  = in_valid && ready;
  assign wr_stb  = accept && (st_q == P_DATA);
  assign wr_addr = addr_q;
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= P_HUNT;
      addr_q <= '0;
    end else if (accept) begin
      unique case (st_q)
        P_HUNT: if (in_data == CMD_PREFIX) st_q <= P_OPC;
        P_OPC:  st_q <= (in_data == OP_REGWR) ? P_ADDR : P_HUNT;
        P_ADDR: begin
          addr_q <= in_data;
          st_q   <= P_DATA;
        end
        P_DATA: st_q <= P_HUNT;
        default: st_q <= P_HUNT;
      endcase
    end
  end

  // R3
  hunt_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st_q == P_HUNT && in_data != CMD_PREFIX) |=> (st_q == P_HUNT));
  // R4
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st_q == P_OPC && in_data != OP_REGWR) |=> (st_q == P_HUNT && !wr_stb));
endmodule

// File: rtl/regcmd_bank.sv
module regcmd_bank
  import regcmd_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [7:0]               wr_addr,
  input  logic [7:0]               wr_data,
  output logic [NUM_REGS-1:0][7:0] active,
  output logic [NUM_REGS-1:0][7:0] shadow,
  output logic                     locked,
  output logic                     commit_now
);
  logic [NUM_REGS-1:0][7:0] active_q, shadow_q;
  logic locked_q, commit_q, in_range;

  assign in_range = (int'(wr_addr) < NUM_REGS) && (wr_addr != GUARD_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      commit_q <= 1'b0;
    end else if (commit_q) begin
      locked_q <= 1'b0;
      commit_q <= 1'b0;
    end else if (wr_stb && is_lock(wr_addr, wr_data)) begin
      locked_q <= 1'b1;
    end else if (wr_stb && is_open(wr_addr, wr_data)) begin
      commit_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_stb && in_range && (int'(wr_addr) == i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end else if (commit_q) begin
        active_q[i] <= shadow_q[i];
      end else if (hit) begin
        shadow_q[i] <= wr_data;
        if (!locked_q) active_q[i] <= wr_data;
      end
    end
  end

  assign active     = active_q;
  assign shadow     = shadow_q;
  assign locked     = locked_q;
  assign commit_now = commit_q;

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && locked_q && !commit_q) |=> $stable(active_q));
  // R5
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wr_addr) >= NUM_REGS) |=> ($stable(shadow_q) && $stable(active_q)));
  // R7
  open_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && is_open(wr_addr, wr_data)) |=> commit_q);
  // R7
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
  // R7
  copy_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> ((active_q == $past(shadow_q)) && !locked_q));
endmodule

// File: rtl/regcmd_power.sv
module regcmd_power
  import regcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit_now,
  input  logic [7:0] shadow_ctl,
  input  logic [7:0] active_ctl,
  output logic       sync_en,
  output logic       power_en
);
  logic       hold_q;
  logic [1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    hold_q <= 1'b1;
    else if (commit_now && shadow_ctl == CTL_RUN)  hold_q <= 1'b0;
    else if (active_ctl == CTL_OFF)                hold_q <= 1'b1;
  end

  assign st       = out_state(active_ctl, hold_q);
  assign power_en = st[1];
  assign sync_en  = st[0];

  // R8
  sync_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |-> power_en);
  // R9
  hold_keeps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !commit_now) |=> (!sync_en && !power_en));
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import regcmd_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  in_ready,
  output logic [NUM_REGS*8-1:0] bank_flat,
  output logic                  locked,
  output logic                  depth_deep,
  output logic [23:0]           base_wide,
  output logic [23:0]           base_narrow,
  output logic                  sync_en,
  output logic                  power_en
);
  logic                     wr_stb, commit_now;
  logic [7:0]               wr_addr, wr_data;
  logic [NUM_REGS-1:0][7:0] active, shadow;

  assign in_ready = !commit_now;

  regcmd_parser u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .ready(in_ready), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  regcmd_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .active(active), .shadow(shadow),
    .locked(locked), .commit_now(commit_now)
  );

  regcmd_power u_pwr (
    .clk(clk), .rst_n(rst_n), .commit_now(commit_now),
    .shadow_ctl(shadow[CTL_IDX]), .active_ctl(active[CTL_IDX]),
    .sync_en(sync_en), .power_en(power_en)
  );

  assign bank_flat   = active;
  assign depth_deep  = active[DEPTH_IDX][0];
  assign base_wide   = {active[BASE_W_IDX], active[BASE_W_IDX+1], active[BASE_W_IDX+2]};
  assign base_narrow = {active[BASE_N_IDX], active[BASE_N_IDX+1], active[BASE_N_IDX+2]};

  // R7
  no_write_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !wr_stb);
endmodule

// File: tb/sim_regcmd_decoder.sv
module sim_regcmd_decoder;
  localparam int NR = 64;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, locked, depth_deep, sync_en, power_en;
  logic [NR*8-1:0] bank_flat;
  logic [23:0] base_wide, base_narrow;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_act [NR];
  logic [7:0] m_sh [NR];
  logic m_locked, m_pd;

  always #2 clk = ~clk;

  regcmd_decoder #(.NUM_REGS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bank_flat(bank_flat), .locked(locked),
    .depth_deep(depth_deep), .base_wide(base_wide), .base_narrow(base_narrow),
    .sync_en(sync_en), .power_en(power_en)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] exp_bank();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = m_act[i];
    return v;
  endfunction

  task automatic check_all(input string tag);
    logic [NR*8-1:0] eb;
    eb = exp_bank();
    checks++;
    if (bank_flat !== eb) begin
      errors++;
      $display("FAIL %s bank: got %h expected %h", tag, bank_flat, eb);
    end
    chk({tag, " locked R6"}, 64'(locked), 64'(m_locked));
    chk({tag, " sync R8 R9"}, 64'(sync_en), 64'(!m_pd && m_act[31] == 8'h00));
    chk({tag, " power R8 R9"}, 64'(power_en), 64'(!m_pd && m_act[31] != 8'h07));
    chk({tag, " depth R10"}, 64'(depth_deep), 64'(m_act[0][0]));
    chk({tag, " base_wide R10"}, 64'(base_wide), 64'({m_act[32], m_act[33], m_act[34]}));
    chk({tag, " base_narrow R10"}, 64'(base_narrow), 64'({m_act[38], m_act[39], m_act[40]}));
  endtask

  // starts and ends on a falling edge
  task automatic send_byte(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] a, input logic [7:0] d);
    send_byte(8'hAF); send_byte(8'h20); send_byte(a); send_byte(d);
    if (a == 8'hFF && d == 8'hFF) begin
      chk("R7 ready low during commit", 64'(in_ready), 64'(0));
      @(negedge clk);
      for (int i = 0; i < NR; i++) m_act[i] = m_sh[i];
      m_locked = 1'b0;
      if (m_sh[31] == 8'h00) m_pd = 1'b0;
      chk("R7 ready back after commit", 64'(in_ready), 64'(1));
    end else if (a == 8'hFF && d == 8'h00) begin
      m_locked = 1'b1;
    end else if (int'(a) < NR) begin
      m_sh[a] = d;
      if (!m_locked) m_act[a] = d;
    end
    if (m_act[31] == 8'h07) m_pd = 1'b1;
  endtask

  function automatic logic [7:0] not_af();
    logic [7:0] b;
    b = 8'($urandom);
    if (b == 8'hAF) b = 8'h5A;
    return b;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) begin m_act[i] = '0; m_sh[i] = '0; end
    m_locked = 1'b0; m_pd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(in_ready), 64'(1));
    check_all("R1 reset");

    // R2 R10 direct writes
    send_cmd(8'h00, 8'h01);
    send_cmd(8'h20, 8'h12); send_cmd(8'h21, 8'h34); send_cmd(8'h22, 8'h56);
    send_cmd(8'h26, 8'hAB); send_cmd(8'h27, 8'hCD); send_cmd(8'h28, 8'hEF);
    check_all("R2 R10 direct");
    chk("R10 base_wide literal", 64'(base_wide), 64'h123456);

    // R3 junk before prefix
    send_byte(8'h00); send_byte(8'h20); send_byte(8'h11);
    send_cmd(8'h05, 8'h77);
    check_all("R3 junk skipped");

    // R4 unknown opcode
    send_byte(8'hAF); send_byte(8'h21); send_byte(8'h05); send_byte(8'h99);
    check_all("R4 unknown opcode");
    send_cmd(8'h06, 8'h42);
    check_all("R4 resync");

    // R5 out of range
    send_cmd(8'h40, 8'h55); send_cmd(8'hFE, 8'h66);
    check_all("R5 out of range");

    // R9 direct write of 0 to control does not power up
    send_cmd(8'h1F, 8'h00);
    check_all("R9 direct run ignored");

    // R6 R7 locked group then commit
    send_cmd(8'hFF, 8'h00);
    send_cmd(8'h05, 8'h10); send_cmd(8'h1F, 8'h00);
    send_cmd(8'hFF, 8'h55);
    check_all("R6 R7 shadow only");
    send_cmd(8'hFF, 8'hFF);
    check_all("R7 R9 commit");
    chk("R9 sync after commit", 64'(sync_en), 64'(1));

    // R8 states
    send_cmd(8'h1F, 8'h01);
    check_all("R8 blanked");
    send_cmd(8'h1F, 8'h03);
    check_all("R8 other value");
    send_cmd(8'h1F, 8'h07);
    check_all("R8 R9 power down");
    send_cmd(8'h1F, 8'h00);
    check_all("R9 stays down");
    send_cmd(8'hFF, 8'h00); send_cmd(8'h1F, 8'h01); send_cmd(8'hFF, 8'hFF);
    check_all("R9 commit non-run");
    send_cmd(8'hFF, 8'h00); send_cmd(8'h1F, 8'h00); send_cmd(8'hFF, 8'hFF);
    check_all("R9 recovered");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [7:0] a, d;
      k = int'($urandom_range(0, 10));
      if (k <= 5) begin
        a = (k == 0) ? 8'h1F : 8'($urandom_range(0, 47));
        d = (a == 8'h1F) ? ((k == 0) ? 8'($urandom_range(0, 2) == 2 ? 7 : $urandom_range(0, 1)) : 8'($urandom))
                         : 8'($urandom);
        send_cmd(a, d);
      end else if (k == 6) send_cmd(8'hFF, 8'h00);
      else if (k == 7) send_cmd(8'hFF, 8'hFF);
      else if (k == 8) send_byte(not_af());
      else if (k == 9) begin
        d = not_af();
        if (d == 8'h20) d = 8'h30;
        send_byte(8'hAF); send_byte(d); send_byte(not_af()); send_byte(not_af());
      end else send_cmd(8'($urandom_range(64, 254)), 8'($urandom));
      check_all("R2 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule